// File: doc/BRIEF.md
# Mode-3 SPI Master with Programmable Select Lead

This block lets a host on the system clock domain exchange a burst of bytes with a register-mapped serial peripheral. The host presents a byte count, a packed write vector, a clock divider ratio and a lead setting, and pulses `start`. The block pulls chip select low and waits a lead time measured in half serial-clock periods. It then shifts the bytes out while capturing the peripheral's reply, and finally releases chip select. A one-cycle `done` pulse marks the moment the received bytes become valid on `rdData`.

The serial clock idles high and data is captured on the second (rising) edge of each bit. The block changes its output data on falling edges. The serial clock is derived from the system clock by an even divider, so a 100 MHz system clock covers serial rates from well under 1 MHz up to 50 MHz. The lead between chip-select assertion and the first serial clock edge is either half a period or a full period, so the lead always ends on a falling edge.

Top module: `spi3_master`

## Requirements
- R1: Out of reset and whenever no transfer runs, `sclk` and `csN` are high, and `busy`, `done` and `rdData` are zero.
- R2: A `start` pulse seen while idle with `numBytes` from 1 to MAX_BYTES drives `csN` low at the next clock edge, and `busy` is high from that edge until the edge where `csN` returns high.
- R3: Every serial clock half period lasts H system clocks, where H is `divRatio` shifted right by one; an odd ratio rounds down, and a ratio below 2 acts as 2.
- R4: The first falling `sclk` edge comes L times H system clocks after `csN` falls, where L is 1 when `leadHalves` is 0 or 1, and 2 when it is 2 or 3.
- R5: Byte 0 (`wrData[7:0]`) goes out first, then byte 1, and so on, each byte MSB first; `mosi` changes only at falling `sclk` edges while `csN` is low.
- R6: `miso` is sampled at each rising `sclk` edge; the first byte received lands in `rdData[7:0]`, the next in `rdData[15:8]`, and bytes at or above index `numBytes` read zero.
- R7: `csN` stays low for all bytes of the transfer, with exactly 8 x `numBytes` clock pulses; after the last rising edge `sclk` stays high for H system clocks before `csN` rises, so `csN` is low for (L + 16 x `numBytes`) x H system clocks.
- R8: `done` is high for exactly one system clock, in the cycle where `csN` has just returned high and `busy` has just fallen; `rdData` holds that result until the next completed transfer.
- R9: A `start` with `numBytes` equal to 0 or above MAX_BYTES is ignored: `csN` stays high, `busy` stays low and `rdData` keeps its value.
- R10: A `start` pulse while `busy` is high is ignored; the running transfer keeps its byte count, its data and its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer (one-cycle pulse) |
| numBytes | input | $clog2(MAX_BYTES+1) | Bytes to transfer, 1..MAX_BYTES |
| divRatio | input | DIV_W | System clocks per serial clock period (even, at least 2) |
| leadHalves | input | 2 | Select-to-first-edge lead in half periods (clamped to 1..2) |
| wrData | input | 8*MAX_BYTES | Packed bytes to send, byte 0 in the low bits |
| rdData | output | 8*MAX_BYTES | Packed bytes received, byte 0 in the low bits |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at completion |
| sclk | output | 1 | Serial clock, idles high |
| csN | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |

## Verification
The edges that are hardest to reach are the lead window and the tail window, where `csN` is low but `sclk` does not toggle. A clamped lead setting or a divider at its floor changes them by only a few system clocks. The bench runs a peripheral model that records the system-clock cycle of every select and clock transition. It sweeps the lead settings 0 through 3 against divider ratios of 1, 2, 5, 6, 8 and 100, so each window length is measured exactly. A second start pulse is injected in the middle of a burst to show that the latched count and data survive it.

// File: rtl/spi3_pkg.sv
package spi3_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_LEAD  = 2'd1,
    S_SHIFT = 2'd2,
    S_TAIL  = 2'd3
  } xferState_t;

  // Strobes from the sequencer to the datapath, one cycle each
  typedef struct packed {
    logic load;   // latch write data, drop chip select
    logic fall;   // drive sclk low, present next mosi bit
    logic rise;   // drive sclk high, capture miso
    logic close;  // raise chip select, publish read data
  } ctrlStrobes_t;

endpackage

// File: rtl/spi3_ctrl.sv
module spi3_ctrl
  import spi3_pkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int DIV_W     = 8,
  parameter int NB_W      = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [NB_W-1:0]  numBytes,
  input  logic [DIV_W-1:0] divRatio,
  input  logic [1:0]       leadHalves,
  output ctrlStrobes_t     strb,
  output logic [NB_W-1:0]  nBytesQ,
  output logic             busy,
  output logic             done
);

  localparam int HALF_W = DIV_W - 1;
  localparam int BIT_W  = $clog2(MAX_BYTES * 8 + 1);

  xferState_t        state;
  logic [HALF_W-1:0] hQ;
  logic [HALF_W-1:0] timer;
  logic [1:0]        halfLeft;
  logic [BIT_W-1:0]  bitsLeft;
  logic              phaseLow;
  logic              halfEnd;
  logic              startOk;
  logic [DIV_W-1:0]  divHalf;
  logic [HALF_W-1:0] hNext;
  logic [1:0]        leadEff;

  assign divHalf = divRatio >> 1;
  assign hNext   = (divHalf == '0) ? HALF_W'(1) : divHalf[HALF_W-1:0];
  assign leadEff = (leadHalves >= 2'd2) ? 2'd2 : 2'd1;
  assign startOk = start && (state == S_IDLE) && (numBytes != '0)
                   && (numBytes <= NB_W'(MAX_BYTES));
  assign halfEnd = (timer == hQ - HALF_W'(1));
  assign busy    = (state != S_IDLE);

  always_comb begin
    strb       = '0;
    strb.load  = startOk;
    strb.fall  = halfEnd && (((state == S_LEAD) && (halfLeft == 2'd1))
                             || ((state == S_SHIFT) && !phaseLow));
    strb.rise  = halfEnd && (state == S_SHIFT) && phaseLow;
    strb.close = halfEnd && (state == S_TAIL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      hQ       <= HALF_W'(1);
      timer    <= '0;
      halfLeft <= '0;
      bitsLeft <= '0;
      phaseLow <= 1'b0;
      nBytesQ  <= '0;
      done     <= 1'b0;
    end else begin
      done <= strb.close;
      if (state == S_IDLE) begin
        timer <= '0;
        if (startOk) begin
          state    <= S_LEAD;
          hQ       <= hNext;
          halfLeft <= leadEff;
          bitsLeft <= BIT_W'(numBytes) << 3;
          phaseLow <= 1'b0;
          nBytesQ  <= numBytes;
        end
      end else begin
        timer <= halfEnd ? '0 : timer + HALF_W'(1);
        if (halfEnd) begin
          unique case (state)
            S_LEAD: begin
              if (halfLeft == 2'd1) begin
                state    <= S_SHIFT;
                phaseLow <= 1'b1;
              end else begin
                halfLeft <= halfLeft - 2'd1;
              end
            end
            S_SHIFT: begin
              if (phaseLow) begin
                phaseLow <= 1'b0;
                bitsLeft <= bitsLeft - BIT_W'(1);
                if (bitsLeft == BIT_W'(1)) state <= S_TAIL;
              end else begin
                phaseLow <= 1'b1;
              end
            end
            S_TAIL:  state <= S_IDLE;
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end

  // R3: at most one datapath action per cycle
  p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.fall, strb.rise, strb.close}));

  // R3: the half-period timer never passes its limit during a transfer
  p_timer_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> (timer < hQ));

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: busy only drops together with done
  p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R10: the latched byte count does not move during a transfer
  p_count_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(nBytesQ));

endmodule

// File: rtl/spi3_datapath.sv
module spi3_datapath
  import spi3_pkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int NB_W      = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strb,
  input  logic [8*MAX_BYTES-1:0] wrData,
  input  logic [NB_W-1:0]        nBytes,
  input  logic                   miso,
  output logic                   sclk,
  output logic                   csN,
  output logic                   mosi,
  output logic [8*MAX_BYTES-1:0] rdData
);

  localparam int TOTAL = 8 * MAX_BYTES;

  logic [TOTAL-1:0] txShift;
  logic [TOTAL-1:0] rxShift;
  logic [TOTAL-1:0] txPacked;
  logic [TOTAL-1:0] rxOrdered;

  // byte 0 is placed at the top so it leaves first
  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_pack
    assign txPacked[TOTAL-1-8*b -: 8] = wrData[8*b +: 8];
  end

  // the first received byte ends up deepest in the shift register
  always_comb begin
    rxOrdered = '0;
    for (int k = 0; k < MAX_BYTES; k++) begin
      if (k < int'(nBytes)) begin
        rxOrdered[8*k +: 8] = rxShift[8*(int'(nBytes) - 1 - k) +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      sclk    <= 1'b1;
      csN     <= 1'b1;
      mosi    <= 1'b1;
      rdData  <= '0;
    end else begin
      if (strb.load) begin
        txShift <= txPacked;
        rxShift <= '0;
        csN     <= 1'b0;
      end
      if (strb.fall) begin
        sclk    <= 1'b0;
        mosi    <= txShift[TOTAL-1];
        txShift <= txShift << 1;
      end
      if (strb.rise) begin
        sclk    <= 1'b1;
        rxShift <= {rxShift[TOTAL-2:0], miso};
      end
      if (strb.close) begin
        csN    <= 1'b1;
        rdData <= rxOrdered;
      end
    end
  end

  // R7: chip select only rises while the clock rests high
  p_cs_rise_sclk_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (sclk && $past(sclk)));

  // R7: the serial clock only toggles low inside a frame
  p_sclk_in_frame_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclk) |-> !csN);

  // R5: outgoing data moves only on a falling serial clock edge
  p_mosi_on_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !$fell(sclk)) |-> $stable(mosi));

  // R1: outside a frame the clock sits at its idle level
  p_idle_level_r1: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN)) |-> sclk);

endmodule

// File: rtl/spi3_master.sv
module spi3_master
  import spi3_pkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int DIV_W     = 8,
  parameter int NB_W      = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [NB_W-1:0]        numBytes,
  input  logic [DIV_W-1:0]       divRatio,
  input  logic [1:0]             leadHalves,
  input  logic [8*MAX_BYTES-1:0] wrData,
  output logic [8*MAX_BYTES-1:0] rdData,
  output logic                   busy,
  output logic                   done,
  output logic                   sclk,
  output logic                   csN,
  output logic                   mosi,
  input  logic                   miso
);

  ctrlStrobes_t    strb;
  logic [NB_W-1:0] nBytesQ;

  spi3_ctrl #(
    .MAX_BYTES(MAX_BYTES),
    .DIV_W    (DIV_W),
    .NB_W     (NB_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .numBytes  (numBytes),
    .divRatio  (divRatio),
    .leadHalves(leadHalves),
    .strb      (strb),
    .nBytesQ   (nBytesQ),
    .busy      (busy),
    .done      (done)
  );

  spi3_datapath #(
    .MAX_BYTES(MAX_BYTES),
    .NB_W     (NB_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wrData(wrData),
    .nBytes(nBytesQ),
    .miso  (miso),
    .sclk  (sclk),
    .csN   (csN),
    .mosi  (mosi),
    .rdData(rdData)
  );

  // R2: a frame only opens in response to start
  p_cs_needs_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> $past(start));

endmodule

// File: tb/spi3_master_tb.sv
`timescale 1ns/1ps
module spi3_master_tb;

  localparam int MAX_BYTES = 4;
  localparam int DIV_W     = 8;
  localparam int NB_W      = $clog2(MAX_BYTES + 1);

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   start = 1'b0;
  logic [NB_W-1:0]        numBytes = '0;
  logic [DIV_W-1:0]       divRatio = 8'd4;
  logic [1:0]             leadHalves = 2'd1;
  logic [8*MAX_BYTES-1:0] wrData = '0;
  logic [8*MAX_BYTES-1:0] rdData;
  logic                   busy, done, sclk, csN, mosi;
  logic                   miso = 1'b1;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  // monitor / peripheral model state
  logic       prevSclk = 1'b1, prevCs = 1'b1;
  int         csFallCyc, csRiseCyc, firstFallCyc, lastEdgeCyc;
  bit         gotFirstFall;
  int         minHalf, maxHalf, fallCount, riseCount, doneCount;
  logic       sclkAtRise, doneAtRise;
  logic [7:0] slTx [MAX_BYTES];
  logic [7:0] slRx [MAX_BYTES];

  spi3_master #(.MAX_BYTES(MAX_BYTES), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .numBytes(numBytes),
    .divRatio(divRatio), .leadHalves(leadHalves), .wrData(wrData),
    .rdData(rdData), .busy(busy), .done(done), .sclk(sclk),
    .csN(csN), .mosi(mosi), .miso(miso)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (prevCs && !csN) begin
      csFallCyc = cyc;
      gotFirstFall = 1'b0;
    end
    if (!prevCs && csN) begin
      csRiseCyc  = cyc;
      sclkAtRise = sclk;
      doneAtRise = done;
    end
    if (done) doneCount++;
    if (prevSclk && !sclk) begin
      if (!gotFirstFall) begin
        firstFallCyc = cyc;
        gotFirstFall = 1'b1;
      end else begin
        if (cyc - lastEdgeCyc < minHalf) minHalf = cyc - lastEdgeCyc;
        if (cyc - lastEdgeCyc > maxHalf) maxHalf = cyc - lastEdgeCyc;
      end
      lastEdgeCyc = cyc;
      if (fallCount < 8 * MAX_BYTES)
        miso = slTx[fallCount / 8][7 - (fallCount % 8)];
      fallCount++;
    end
    if (!prevSclk && sclk) begin
      if (cyc - lastEdgeCyc < minHalf) minHalf = cyc - lastEdgeCyc;
      if (cyc - lastEdgeCyc > maxHalf) maxHalf = cyc - lastEdgeCyc;
      lastEdgeCyc = cyc;
      if (riseCount < 8 * MAX_BYTES)
        slRx[riseCount / 8][7 - (riseCount % 8)] = mosi;
      riseCount++;
    end
    prevSclk = sclk;
    prevCs   = csN;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearMon();
    minHalf = 1 << 30; maxHalf = 0; fallCount = 0; riseCount = 0;
    doneCount = 0; gotFirstFall = 1'b0; sclkAtRise = 1'b0; doneAtRise = 1'b0;
    csFallCyc = 0; csRiseCyc = 0; firstFallCyc = 0;
    for (int i = 0; i < MAX_BYTES; i++) slRx[i] = 8'h00;
  endtask

  task automatic waitDone();
    int guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(done, "R8 completion reached", done, 1);
    @(negedge clk);
    @(negedge clk);
  endtask

  // runs one transfer and checks timing and data against the requirements
  task automatic runXfer(input int n, input int div, input int lead,
                         input logic [31:0] wr, input logic [31:0] slv,
                         input bit injectStart);
    int h, l;
    logic [31:0] expRd;
    h = (div >> 1) == 0 ? 1 : (div >> 1);
    l = (lead >= 2) ? 2 : 1;
    for (int i = 0; i < MAX_BYTES; i++) slTx[i] = slv[8*i +: 8];
    clearMon();
    @(negedge clk);
    numBytes = NB_W'(n); divRatio = DIV_W'(div); leadHalves = 2'(lead);
    wrData = wr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && csN === 1'b0, "R2 busy and select after start", {busy, csN}, 2'b10);
    if (injectStart) begin
      repeat (3 * h) @(negedge clk);
      numBytes = NB_W'(MAX_BYTES); wrData = ~wr; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waitDone();
    expRd = '0;
    for (int i = 0; i < n; i++) expRd[8*i +: 8] = slv[8*i +: 8];
    chk(firstFallCyc - csFallCyc == l * h, "R4 lead length", firstFallCyc - csFallCyc, l * h);
    chk(minHalf == h && maxHalf == h, "R3 half period", {minHalf, maxHalf}, {h, h});
    chk(fallCount == 8 * n && riseCount == 8 * n, "R7 pulse count", fallCount, 8 * n);
    chk(csRiseCyc - csFallCyc == (l + 16 * n) * h, "R7 select low time",
        csRiseCyc - csFallCyc, (l + 16 * n) * h);
    chk(sclkAtRise === 1'b1, "R7 sclk high at select release", sclkAtRise, 1);
    for (int i = 0; i < n; i++)
      chk(slRx[i] === wr[8*i +: 8], "R5 mosi byte", slRx[i], wr[8*i +: 8]);
    chk(rdData === expRd, "R6 read data", rdData, expRd);
    chk(doneCount == 1 && doneAtRise === 1'b1, "R8 done one cycle at release",
        doneCount, 1);
    chk(busy === 1'b0 && csN === 1'b1 && sclk === 1'b1, "R1 idle after transfer",
        {busy, csN, sclk}, 3'b011);
  endtask

  task automatic t_reset();
    chk(csN === 1'b1 && sclk === 1'b1, "R1 pins after reset", {csN, sclk}, 2'b11);
    chk(busy === 1'b0 && done === 1'b0 && rdData === '0, "R1 status after reset",
        {busy, done}, 0);
  endtask

  task automatic t_badLength(input int n);
    logic [31:0] held;
    held = rdData;
    clearMon();
    @(negedge clk);
    numBytes = NB_W'(n); wrData = 32'hFFFF_FFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk(csN === 1'b1 && busy === 1'b0 && fallCount == 0, "R9 bad length ignored",
        {csN, busy}, 2'b10);
    chk(rdData === held && doneCount == 0, "R9 read data kept", rdData, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    runXfer(1, 4, 1, 32'h0000_00A5, 32'h0000_003C, 1'b0);
    runXfer(4, 6, 2, 32'h1122_3344, 32'hC3D2_E1F0, 1'b0);
    runXfer(2, 8, 0, 32'hFFFF_5A96, 32'h8888_7E01, 1'b0);
    runXfer(1, 4, 3, 32'h0000_0081, 32'h0000_0042, 1'b0);
    runXfer(3, 2, 1, 32'h00C0_FFEE, 32'h0012_3456, 1'b0);
    runXfer(1, 5, 1, 32'h0000_0033, 32'h0000_00CC, 1'b0);
    runXfer(2, 1, 2, 32'h0000_A1B2, 32'h0000_0F0F, 1'b0);
    runXfer(1, 100, 1, 32'h0000_006D, 32'h0000_00B9, 1'b0);
    t_badLength(0);
    t_badLength(5);
    runXfer(1, 6, 1, 32'h0000_0057, 32'h0000_00E4, 1'b1); // R10 start during busy
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule